// File: doc/BRIEF.md
# Triggered PWM Timer with Restart

This block is a down-counting pulse-width generator. Software programs a period value and a high-time value through a small write-only register port, then starts it either by a self-clearing software trigger bit or by a rising edge on an asynchronous external trigger pin. Once started, the counter loads the period value and steps down once per count tick. The output is HIGH while the count is at or below the high-time value. At zero the counter either reloads (continuous mode) or stops (one-shot mode).

A trigger that arrives while the counter runs is either ignored or restarts the period, as software selects. The period value is staged: writing it alone changes nothing, and the following high-time write commits both together. The committed values, and an output-mask bit that forces the output LOW, are taken into use only at the next counter load. Three event flags (underflow, high-time match, accepted trigger) each have an enable. They feed two interrupt lines. Each flag is cleared by software or by a per-line DMA acknowledge, and a set in the same cycle as a clear wins.

Top module: `trig_pwm_timer`

## Requirements
- R1: After reset, `pwm_o`, both interrupt lines, `flags_o` and `count_o` are all 0 and the counter is idle.
- R2: In continuous mode with `cnt_tick_i` high, the count runs cycle, cycle-1, …, 0 and then reloads to cycle, so one period is cycle+1 ticks. `pwm_o` is HIGH exactly while count ≤ duty, which gives a constant HIGH when duty equals cycle. While `cnt_tick_i` is low the count holds.
- R3: In one-shot mode (control bit 1 = 1), one period is produced. The tick at count 0 then stops the counter with the count at 0 and `pwm_o` LOW.
- R4: A trigger that arrives while running is ignored when restart is off (control bit 2 = 0): the count sequence is unchanged and the trigger flag is not set. With restart on, the trigger reloads the count to cycle and sets the trigger flag.
- R5: The counter loads two clock edges after the edge that captures a software trigger (control register, address 0, bit 7 = 1). It loads on the third clock edge after the edge that first samples `ext_trig_i` high.
- R6: Flag bit 0 is set by a tick at count 0. Flag bit 1 is set when the count takes the duty value, by a step or a load. Flag bit 2 is set by an accepted trigger.
- R7: `irq_cyc_o` is high when (flag0 and enable bit 4) or (flag1 and enable bit 5), with the enables in status register address 1. `irq_trg_o` is high when flag2 and enable bit 6.
- R8: Writing status address 1 clears each flag whose bit in [2:0] is 0 and leaves flags written with 1 untouched. `dma_ack_i[0]` clears flags 0 and 1, and `dma_ack_i[1]` clears flag 2. A set in the same cycle as a clear leaves the flag set.
- R9: A load (trigger) in the same cycle as a count step wins. The count becomes cycle, and a one-shot restart at count 0 runs a further period.
- R10: A write to the cycle register (address 2) alone has no effect. A write to the duty register (address 3) commits the staged cycle together with the new duty, and both take effect at the next reload, never mid-period.
- R11: Setting the mask bit (control bit 3) holds `pwm_o` LOW, starting at the next reload, while the count continues.
- R12: With run enable (control bit 0) at 0, the counter clears to 0 and stops, `pwm_o` is LOW, and triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick_i | input | 1 | Count step enable from the prescaler |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 cycle, 3 duty |
| reg_wdata_i | input | DATA_W | Register write data |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| dma_ack_i | input | 2 | DMA acknowledge per interrupt line |
| pwm_o | output | 1 | PWM output |
| irq_cyc_o | output | 1 | Interrupt line for underflow and duty match |
| irq_trg_o | output | 1 | Interrupt line for trigger |
| count_o | output | CNT_W | Current count |
| flags_o | output | 3 | Event flags {trigger, duty match, underflow} |

## Verification
The assertions assume that `ext_trig_i` is the only asynchronous input and that every other input changes away from the active edge. They also assume the period and duty values are not reprogrammed and committed in the same cycle as a reload they are meant to miss. The stimulus drives all inputs on the falling edge. It sweeps every duty value up to each small cycle value. Software triggers are placed so that they fall on chosen count values, including a count of 0, which lets the coincidence rules be observed deterministically.

// File: rtl/trig_pwm_pkg.sv
// Shared constants and types for the triggered PWM timer.
// Assumes a 2-bit register address space and at least 8 data bits.
package trig_pwm_pkg;
    localparam int unsigned FLAG_N   = 3;
    localparam int unsigned FLAG_UF  = 0;
    localparam int unsigned FLAG_DM  = 1;
    localparam int unsigned FLAG_TG  = 2;
    localparam int unsigned ENA_LSB  = 4;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CYC  = 2'd2;
    localparam logic [1:0] ADDR_DUTY = 2'd3;

    localparam int unsigned CTL_EN      = 0;
    localparam int unsigned CTL_ONESHOT = 1;
    localparam int unsigned CTL_RESTART = 2;
    localparam int unsigned CTL_MASK    = 3;
    localparam int unsigned CTL_SWTRIG  = 7;

    typedef struct packed {
        logic en;
        logic oneshot;
        logic restart;
        logic mask;
    } ctrl_t;
endpackage

// File: rtl/trig_pwm_sync.sv
// Synchroniser plus rising-edge detector for the external trigger.
// Assumes STAGES >= 2; produces a one-clock pulse per rising edge.
module trig_pwm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the flop chain and keep the last synced value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // R5: an edge gives a single-cycle pulse
    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/trig_pwm_regs.sv
// Write-only register file: control, interrupt enables, staged cycle,
// committed cycle/duty pair and the self-clearing software trigger.
// Assumes DATA_W >= CNT_W and DATA_W >= 8.
module trig_pwm_regs
    import trig_pwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic              sw_trig_o,
    output logic [CNT_W-1:0]  cyc_pend_o,
    output logic [CNT_W-1:0]  duty_pend_o,
    output logic [FLAG_N-1:0] ena_o,
    output logic              flag_wr_o,
    output logic [FLAG_N-1:0] flag_wdata_o
);
    ctrl_t             ctrl_q;
    logic              sw_trig_q;
    logic [CNT_W-1:0]  cyc_stage_q;
    logic [CNT_W-1:0]  cyc_pend_q;
    logic [CNT_W-1:0]  duty_pend_q;
    logic [FLAG_N-1:0] ena_q;

    // Decode writes; the duty write commits the staged cycle value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            sw_trig_q   <= 1'b0;
            cyc_stage_q <= '0;
            cyc_pend_q  <= '0;
            duty_pend_q <= '0;
            ena_q       <= '0;
        end else begin
            sw_trig_q <= 1'b0;
            if (wr_i) begin
                unique case (addr_i)
                    ADDR_CTRL: begin
                        ctrl_q.en      <= wdata_i[CTL_EN];
                        ctrl_q.oneshot <= wdata_i[CTL_ONESHOT];
                        ctrl_q.restart <= wdata_i[CTL_RESTART];
                        ctrl_q.mask    <= wdata_i[CTL_MASK];
                        sw_trig_q      <= wdata_i[CTL_SWTRIG];
                    end
                    ADDR_STAT: ena_q <= wdata_i[ENA_LSB +: FLAG_N];
                    ADDR_CYC:  cyc_stage_q <= wdata_i[CNT_W-1:0];
                    ADDR_DUTY: begin
                        cyc_pend_q  <= cyc_stage_q;
                        duty_pend_q <= wdata_i[CNT_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ctrl_o       = ctrl_q;
    assign sw_trig_o    = sw_trig_q;
    assign cyc_pend_o   = cyc_pend_q;
    assign duty_pend_o  = duty_pend_q;
    assign ena_o        = ena_q;
    assign flag_wr_o    = wr_i && (addr_i == ADDR_STAT);
    assign flag_wdata_o = wdata_i[FLAG_N-1:0];

    // R10: a cycle write alone leaves the committed value alone
    p_stage_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_CYC) |=> $stable(cyc_pend_q));
endmodule

// File: rtl/trig_pwm_core.sv
// Down counter, reload, duty compare and output shaping.
// Takes period, duty and mask into use only at a load or reload.
// Assumes trig_i is a single-cycle pulse in the clk domain.
module trig_pwm_core
    import trig_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  ctrl_t            ctrl_i,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] cyc_pend_i,
    input  logic [CNT_W-1:0] duty_pend_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_o,
    output logic             uf_evt_o,
    output logic             dm_evt_o,
    output logic             tg_evt_o
);
    logic             run_q, run_n;
    logic             mask_q, mask_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] cyc_q, cyc_n;
    logic [CNT_W-1:0] duty_q, duty_n;
    logic             load, step, wrap, upd;

    // Next-state: disable, then load (wins over count), then wrap, then step.
    always_comb begin
        load   = trig_i && ctrl_i.en && (!run_q || ctrl_i.restart);
        step   = ctrl_i.en && run_q && tick_i && !load;
        wrap   = step && (cnt_q == '0);
        run_n  = run_q;
        cnt_n  = cnt_q;
        cyc_n  = cyc_q;
        duty_n = duty_q;
        mask_n = mask_q;
        upd    = 1'b0;
        if (!ctrl_i.en) begin
            run_n = 1'b0;
            cnt_n = '0;
        end else if (load || (wrap && !ctrl_i.oneshot)) begin
            run_n  = 1'b1;
            cnt_n  = cyc_pend_i;
            cyc_n  = cyc_pend_i;
            duty_n = duty_pend_i;
            mask_n = ctrl_i.mask;
            upd    = 1'b1;
        end else if (wrap) begin
            run_n = 1'b0;
        end else if (step) begin
            cnt_n = cnt_q - CNT_W'(1);
            upd   = 1'b1;
        end
    end

    // Counter and active-period state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mask_q <= 1'b0;
            cnt_q  <= '0;
            cyc_q  <= '0;
            duty_q <= '0;
        end else begin
            run_q  <= run_n;
            mask_q <= mask_n;
            cnt_q  <= cnt_n;
            cyc_q  <= cyc_n;
            duty_q <= duty_n;
        end
    end

    assign cnt_o    = cnt_q;
    assign pwm_o    = run_q && !mask_q && (cnt_q <= duty_q);
    assign uf_evt_o = wrap;
    assign dm_evt_o = upd && (cnt_n == duty_n);
    assign tg_evt_o = load;

    // R2: count never exceeds the active period value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= cyc_q));
    // R2: one step down per tick away from zero
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.en && run_q && tick_i && !trig_i && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    // R2: no tick, no trigger: count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.en && !tick_i && !trig_i) |=> $stable(cnt_q));
    // R3: one-shot stops at the end of its period
    p_oneshot_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.en && ctrl_i.oneshot && run_q && tick_i && !trig_i && cnt_q == '0)
        |=> (!run_q && !pwm_o));
    // R9: an accepted trigger loads the period regardless of a tick
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (run_q && cnt_q == $past(cyc_pend_i)));
    // R12: idle output is LOW
    p_idle_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !pwm_o);
endmodule

// File: rtl/trig_pwm_flags.sv
// Event flags with set-over-clear priority; cleared by a status write
// of 0 or by an acknowledge. One flop per flag built by generate.
module trig_pwm_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] ack_clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;

        // Set has priority over both clear sources.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_i[i]) begin
                flag_q <= 1'b1;
            end else if ((wr_i && !wdata_i[i]) || ack_clr_i[i]) begin
                flag_q <= 1'b0;
            end
        end

        assign flag_o[i] = flag_q;

        // R8: a set always lands, even against a clear
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q);
    end
endmodule

// File: rtl/trig_pwm_timer.sv
// Top level of the triggered PWM timer: registers, trigger path,
// counter core, flags and the two interrupt lines.
// Assumes cnt_tick_i comes from a prescaler in the clk domain.
module trig_pwm_timer
    import trig_pwm_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic              ext_trig_i,
    input  logic [1:0]        dma_ack_i,
    output logic              pwm_o,
    output logic              irq_cyc_o,
    output logic              irq_trg_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [FLAG_N-1:0] flags_o
);
    ctrl_t             ctrl;
    logic              sw_trig, ext_rise, trig;
    logic [CNT_W-1:0]  cyc_pend, duty_pend;
    logic [FLAG_N-1:0] ena, flag_wdata, flag_set, ack_clr;
    logic              flag_wr, uf_evt, dm_evt, tg_evt;

    trig_pwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .ctrl_o       (ctrl),
        .sw_trig_o    (sw_trig),
        .cyc_pend_o   (cyc_pend),
        .duty_pend_o  (duty_pend),
        .ena_o        (ena),
        .flag_wr_o    (flag_wr),
        .flag_wdata_o (flag_wdata)
    );

    trig_pwm_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_trig_i),
        .rise_o  (ext_rise)
    );

    assign trig = sw_trig | ext_rise;

    trig_pwm_core #(.CNT_W(CNT_W)) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (cnt_tick_i),
        .ctrl_i      (ctrl),
        .trig_i      (trig),
        .cyc_pend_i  (cyc_pend),
        .duty_pend_i (duty_pend),
        .cnt_o       (count_o),
        .pwm_o       (pwm_o),
        .uf_evt_o    (uf_evt),
        .dm_evt_o    (dm_evt),
        .tg_evt_o    (tg_evt)
    );

    assign flag_set = {tg_evt, dm_evt, uf_evt};
    assign ack_clr  = {dma_ack_i[1], dma_ack_i[0], dma_ack_i[0]};

    trig_pwm_flags #(.N(FLAG_N)) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (flag_set),
        .wr_i      (flag_wr),
        .wdata_i   (flag_wdata),
        .ack_clr_i (ack_clr),
        .flag_o    (flags_o)
    );

    assign irq_cyc_o = (flags_o[FLAG_UF] & ena[FLAG_UF]) | (flags_o[FLAG_DM] & ena[FLAG_DM]);
    assign irq_trg_o = flags_o[FLAG_TG] & ena[FLAG_TG];

    // R6: an underflow event shows up in flag bit 0
    p_uf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> flags_o[FLAG_UF]);
    // R6: an accepted trigger shows up in flag bit 2
    p_tg_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tg_evt |=> flags_o[FLAG_TG]);
    // R7: an enabled trigger flag raises its line one cycle after the event
    p_trg_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tg_evt && ena[FLAG_TG] && !(reg_wr_i && reg_addr_i == ADDR_STAT)) |=> irq_trg_o);
endmodule

// File: tb/test_trig_pwm_timer.sv
`timescale 1ns/1ps
module test_trig_pwm_timer;
    localparam int CNT_W = 16;
    localparam int DATA_W = 16;
    localparam int EN = 1, ONE = 2, RST = 4, MSK = 8, TRG = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic wr = 1'b0;
    logic [1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic ext = 1'b0;
    logic [1:0] ack = '0;
    logic pwm, irq_c, irq_t;
    logic [CNT_W-1:0] count;
    logic [2:0] flags;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trig_pwm_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_trig_pwm_timer (
        .clk(clk), .rst_n(rst_n), .cnt_tick_i(tick), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .ext_trig_i(ext),
        .dma_ack_i(ack), .pwm_o(pwm), .irq_cyc_o(irq_c), .irq_trg_o(irq_t),
        .count_o(count), .flags_o(flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input int d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = DATA_W'(d);
        @(negedge clk);
        wr = 1'b0;
    endtask

    function automatic int model(input int c, input int t0, input int now);
        return c - ((now - t0) % (c + 1));
    endfunction

    // start a run; returns the cycle stamp at which the load is visible
    task automatic start(input int c, input int d, input int mode, output int t0);
        reg_write(2'd0, 0);
        reg_write(2'd2, c);
        reg_write(2'd3, d);
        reg_write(2'd0, mode | EN | TRG);
        t0 = cyc + 1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, cc, e, v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwm", pwm, 0);
        chk("R1 irq", {irq_c, irq_t}, 0);
        chk("R1 flags", flags, 0);
        chk("R1 count", count, 0);

        // R2/R5 sweep every duty up to each cycle value, continuous
        for (int c = 0; c <= 5; c++) begin
            for (int d = 0; d <= c; d++) begin
                start(c, d, 0, t0);
                for (int k = 0; k < 2 * (c + 1); k++) begin
                    @(negedge clk);
                    e = model(c, t0, cyc);
                    if (k == 0) chk("R5 sw load latency", count, c);
                    else chk("R2 count", count, e);
                    chk("R2 pwm", pwm, (e <= d) ? 1 : 0);
                end
            end
        end

        // R3 one-shot
        start(3, 1, ONE, t0);
        for (int j = 0; j <= 8; j++) begin
            @(negedge clk);
            e = (j <= 3) ? 3 - j : 0;
            chk("R3 oneshot count", count, e);
            chk("R3 oneshot pwm", pwm, (j <= 3 && e <= 1) ? 1 : 0);
        end

        // R9 one-shot restart coinciding with the last tick
        start(3, 1, ONE | RST, t0);
        repeat (2) @(negedge clk);
        reg_write(2'd0, ONE | RST | EN | TRG);
        chk("R9 at zero", count, 0);
        for (int j = 0; j <= 4; j++) begin
            @(negedge clk);
            e = (j <= 3) ? 3 - j : 0;
            chk("R9 oneshot rerun count", count, e);
            chk("R9 oneshot rerun pwm", pwm, (j <= 3 && e <= 1) ? 1 : 0);
        end

        // R4 trigger ignored while running without restart
        start(7, 2, 0, t0);
        reg_write(2'd1, 0);
        reg_write(2'd0, EN | TRG);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            chk("R4 ignore count", count, model(7, t0, cyc));
        end
        chk("R4 ignore no trig flag", flags[2], 0);

        // R4/R9 restart on trigger, load wins over the tick
        reg_write(2'd0, EN | RST | TRG);
        t0 = cyc + 1;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            chk("R9 restart count", count, model(7, t0, cyc));
        end
        chk("R4 restart trig flag", flags[2], 1);

        // R2 count holds without a tick
        tick = 1'b0;
        @(negedge clk);
        v = count;
        repeat (3) begin
            @(negedge clk);
            chk("R2 hold without tick", count, v);
        end
        tick = 1'b1;

        // R5 external trigger latency
        reg_write(2'd0, 0);
        reg_write(2'd2, 4);
        reg_write(2'd3, 2);
        reg_write(2'd0, EN);
        ext = 1'b1;
        @(negedge clk); chk("R5 ext edge+1", count, 0);
        @(negedge clk); chk("R5 ext edge+2", count, 0);
        @(negedge clk); chk("R5 ext edge+3 load", count, 4);
        t0 = cyc;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            chk("R5 ext level no retrigger", count, model(4, t0, cyc));
        end
        ext = 1'b0;

        // R6/R7/R8 flags and interrupt lines
        reg_write(2'd0, 0);
        reg_write(2'd1, 0);
        chk("R8 write-zero clear", flags, 0);
        start(3, 1, 0, t0);
        repeat (6) @(negedge clk);
        chk("R6 all flags set", flags, 7);
        chk("R7 lines off when disabled", {irq_c, irq_t}, 0);
        reg_write(2'd1, 8'h77);
        chk("R8 write-one keeps flag", flags[2], 1);
        chk("R7 both lines", {irq_c, irq_t}, 3);
        reg_write(2'd1, 8'h73);
        chk("R8 clear trig flag", flags[2], 0);
        chk("R7 trig line low", irq_t, 0);
        chk("R7 cycle line high", irq_c, 1);
        for (int j = 0; j < 8 && count != 0; j++) @(negedge clk);
        ack = 2'b01;
        @(negedge clk);
        ack = 2'b00;
        chk("R8 set wins over ack", flags[0], 1);
        chk("R8 ack clears duty flag", flags[1], 0);
        reg_write(2'd0, 0);
        @(negedge clk);
        ack = 2'b01;
        @(negedge clk);
        ack = 2'b00;
        chk("R8 ack0 clears", flags[1:0], 0);
        chk("R7 cycle line low", irq_c, 0);
        reg_write(2'd0, EN | TRG);
        reg_write(2'd0, 0);
        chk("R6 trig flag", flags[2], 1);
        ack = 2'b10;
        @(negedge clk);
        ack = 2'b00;
        chk("R8 ack1 clears", flags[2], 0);

        // R10 staged cycle, committed by duty, applied at reload
        start(3, 1, 0, t0);
        reg_write(2'd2, 5);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk("R10 stage only", count, model(3, t0, cyc));
        end
        reg_write(2'd3, 2);
        cc = cyc;
        t1 = t0 + 4 * ((cc - t0) / 4 + 1);
        for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            if (cyc < t1) begin
                e = model(3, t0, cyc);
                chk("R10 old period", count, e);
                chk("R10 old pwm", pwm, (e <= 1) ? 1 : 0);
            end else begin
                e = model(5, t1, cyc);
                chk("R10 new period", count, e);
                chk("R10 new pwm", pwm, (e <= 2) ? 1 : 0);
            end
        end

        // R11 mask from the next period
        reg_write(2'd0, EN | MSK);
        cc = cyc;
        t2 = t1 + 6 * ((cc - t1) / 6 + 1);
        for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            e = model(5, (cyc < t2) ? t1 : t2, cyc);
            chk("R11 count continues", count, e);
            chk("R11 pwm", pwm, (cyc < t2 && e <= 2) ? 1 : 0);
        end

        // R12 run enable off
        reg_write(2'd0, 0);
        @(negedge clk);
        chk("R12 count cleared", count, 0);
        chk("R12 pwm low", pwm, 0);
        reg_write(2'd0, TRG);
        repeat (3) @(negedge clk);
        chk("R12 trigger ignored", count, 0);
        chk("R12 pwm stays low", pwm, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule